// File: doc/BRIEF.md
# Boundary-Scan Pad Cell Chain

This block is the boundary-scan data register placed around a row of general-purpose pads. Every pad adds three scan cells to the chain: one for the value arriving from the pad, one for the value the core wants to drive, and one for the core's drive enable. Each of these cells pairs a shift flop with an update flop. A final cell watches the external reset pin. It can only be captured and shifted, and it never drives anything.

An external test access port controller supplies single-cycle capture, shift and update strobes, all sampled on the test clock, along with a chain-select qualifier. An external instruction decoder supplies two mode bits. The pad-drive override mode puts the update flops in control of the pad output and pad enable. The core-input override mode puts them in control of the inputs the core sees. With neither mode bit set, every signal passes straight through. The chain keeps working in either mode, so new values can be captured, shifted and preloaded while an override is in force.

Top module: `bscan_pad_chain`

## Requirements
- R1: After reset, every shift flop and every update flop holds 0, so `tdo` is 0 and, with both mode bits low, `pad_out`, `pad_oe` and `core_in` equal `core_out`, `core_oe` and `pad_in`.
- R2: When `chain_sel` and `capture_dr` are both high at a clock edge, the chain loads the rst_pin value into chain bit 0 and, for each pad p, loads `pad_in[p]` into bit 3p+1, `core_out[p]` into bit 3p+2 and `core_oe[p]` into bit 3p+3. Capture wins when `shift_dr` is also high.
- R3: When `chain_sel` and `shift_dr` are high and `capture_dr` is low, every bit moves one place toward bit 0 on each edge. `tdi` enters the top bit, and `tdo` always shows bit 0.
- R4: The chain is 3*NUM_PADS+1 bits long. The first bit shifted in from `tdi` appears on `tdo` after exactly that many shifts.
- R5: When `chain_sel` and `update_dr` are high, the update flops of the pad cells copy their shift flops. At all other times, including during shifting, the update flops hold their value.
- R6: While `extest_en` is high, `pad_out[p]` and `pad_oe[p]` come from the update flops of the output cell and the enable cell of pad p, and they do not depend on `core_out` or `core_oe`.
- R7: While `intest_en` is high, `core_in[p]` comes from the update flop of the input cell of pad p, and it does not depend on `pad_in`.
- R8: `core_rst_in` always equals `rst_pin`, in every mode.
- R9: While a mode bit is low, the signals it governs pass through unchanged. The two mode bits act independently of each other.
- R10: While `chain_sel` is low, the capture, shift and update strobes have no effect: `tdo` and the update flops do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset of the chain (test logic reset) |
| chain_sel | input | 1 | The current instruction selects this chain |
| capture_dr | input | 1 | Capture strobe, one cycle |
| shift_dr | input | 1 | Shift enable |
| update_dr | input | 1 | Update strobe, one cycle |
| extest_en | input | 1 | Pad-drive override mode |
| intest_en | input | 1 | Core-input override mode |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| core_out | input | NUM_PADS | Output values from the core |
| core_oe | input | NUM_PADS | Output enables from the core |
| pad_in | input | NUM_PADS | Values received at the pads |
| rst_pin | input | 1 | External reset pin level, observe only |
| pad_out | output | NUM_PADS | Output values to the pads |
| pad_oe | output | NUM_PADS | Output enables to the pads |
| core_in | output | NUM_PADS | Input values to the core |
| core_rst_in | output | 1 | Reset pin level passed to the core |

## Verification
If a shift flop is stuck or the chain links are crossed, the fault shows on `tdo` within 3*NUM_PADS+1 shifts after a capture, because every cell position carries a distinct known value. If an update flop takes a wrong value, or changes when it should hold, the fault shows one edge later on `pad_out`, `pad_oe` or `core_in` once the matching override is on. Ignored strobes are checked by watching `tdo` and the overridden outputs after a deselected strobe.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   localparam int CELLS_PER_PAD = 3;
   localparam int RST_CELL      = 0;
   localparam int OFS_IN        = 1;
   localparam int OFS_OUT       = 2;
   localparam int OFS_OE        = 3;

   function automatic int chain_len(input int pads);
      return CELLS_PER_PAD * pads + 1;
   endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
   parameter bit HAS_UPDATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic capture,
   input  logic shift,
   input  logic update,
   input  logic par_in,
   input  logic shift_in,
   output logic shift_q,
   output logic upd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                shift_q <= 1'b0;
      else if (sel && capture)   shift_q <= par_in;
      else if (sel && shift)     shift_q <= shift_in;
   end

   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && capture) |=> (shift_q == $past(par_in)));                  // R2
   AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && shift && !capture) |=> (shift_q == $past(shift_in)));      // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel) |=> $stable(shift_q));                                       // R10

   generate
      if (HAS_UPDATE) begin : g_upd
         logic upd_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              upd_r <= 1'b0;
            else if (sel && update)  upd_r <= shift_q;
         end
         assign upd_q = upd_r;

         AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel && update) |=> $stable(upd_q));                         // R5
         AST_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && update) |=> (upd_q == $past(shift_q)));               // R5
      end else begin : g_obs
         assign upd_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bsr_pad.sv
module bsr_pad (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic capture,
   input  logic shift,
   input  logic update,
   input  logic extest_en,
   input  logic intest_en,
   input  logic core_out,
   input  logic core_oe,
   input  logic pad_in,
   input  logic si,
   output logic so,
   output logic pad_out,
   output logic pad_oe,
   output logic core_in
);
   logic q_in, q_out, q_oe;
   logic u_in, u_out, u_oe;

   // shift order inside a pad: si -> enable cell -> output cell -> input cell -> so
   bsr_cell #(.HAS_UPDATE(1'b1)) u_oe_cell (
      .clk, .rst_n, .sel, .capture, .shift, .update,
      .par_in(core_oe), .shift_in(si), .shift_q(q_oe), .upd_q(u_oe));
   bsr_cell #(.HAS_UPDATE(1'b1)) u_out_cell (
      .clk, .rst_n, .sel, .capture, .shift, .update,
      .par_in(core_out), .shift_in(q_oe), .shift_q(q_out), .upd_q(u_out));
   bsr_cell #(.HAS_UPDATE(1'b1)) u_in_cell (
      .clk, .rst_n, .sel, .capture, .shift, .update,
      .par_in(pad_in), .shift_in(q_out), .shift_q(q_in), .upd_q(u_in));

   assign so      = q_in;
   assign pad_out = extest_en ? u_out : core_out;
   assign pad_oe  = extest_en ? u_oe  : core_oe;
   assign core_in = intest_en ? u_in  : pad_in;

   AST_EXT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (extest_en && $past(extest_en) && !$past(sel && update))
         |-> ($stable(pad_out) && $stable(pad_oe)));                      // R6
   AST_INT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (intest_en && $past(intest_en) && !$past(sel && update))
         |-> $stable(core_in));                                           // R7
endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain #(
   parameter int NUM_PADS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chain_sel,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                extest_en,
   input  logic                intest_en,
   input  logic                tdi,
   output logic                tdo,
   input  logic [NUM_PADS-1:0] core_out,
   input  logic [NUM_PADS-1:0] core_oe,
   input  logic [NUM_PADS-1:0] pad_in,
   input  logic                rst_pin,
   output logic [NUM_PADS-1:0] pad_out,
   output logic [NUM_PADS-1:0] pad_oe,
   output logic [NUM_PADS-1:0] core_in,
   output logic                core_rst_in
);
   import bsr_pkg::*;

   localparam int CHAIN_LEN = chain_len(NUM_PADS);

   generate
      if (NUM_PADS < 1) begin : g_bad_pads
         $error("bscan_pad_chain: NUM_PADS must be at least 1");
      end
      if (CHAIN_LEN != CELLS_PER_PAD * NUM_PADS + 1) begin : g_bad_len
         $error("bscan_pad_chain: chain length mismatch");
      end
   endgenerate

   // link[p] is the serial output of pad p; link[NUM_PADS] is the chain head
   logic [NUM_PADS:0] link;
   assign link[NUM_PADS] = tdi;

   genvar p;
   generate
      for (p = 0; p < NUM_PADS; p++) begin : g_pad
         bsr_pad u_pad (
            .clk, .rst_n,
            .sel(chain_sel), .capture(capture_dr), .shift(shift_dr), .update(update_dr),
            .extest_en, .intest_en,
            .core_out(core_out[p]), .core_oe(core_oe[p]), .pad_in(pad_in[p]),
            .si(link[p+1]), .so(link[p]),
            .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .core_in(core_in[p]));
      end
   endgenerate

   logic rst_cell_q;
   logic rst_cell_unused;

   bsr_cell #(.HAS_UPDATE(1'b0)) u_rst_cell (
      .clk, .rst_n,
      .sel(chain_sel), .capture(capture_dr), .shift(shift_dr), .update(update_dr),
      .par_in(rst_pin), .shift_in(link[0]), .shift_q(rst_cell_q), .upd_q(rst_cell_unused));

   assign tdo         = rst_cell_q;
   assign core_rst_in = rst_pin;

   AST_TDO_FROM_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_sel && shift_dr && !capture_dr) |=> (tdo == $past(link[0])));  // R3
   AST_TDO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_sel && capture_dr) |=> (tdo == $past(rst_pin)));               // R2
   AST_RST_OBSERVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (extest_en || intest_en) |-> (core_rst_in == rst_pin));               // R8
endmodule

// File: tb/sim_bscan_pad_chain.sv
module sim_bscan_pad_chain;
   localparam int N = 4;
   localparam int L = 3 * N + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chain_sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic extest_en = 1'b0, intest_en = 1'b0, tdi = 1'b0;
   logic tdo;
   logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
   logic rst_pin = 1'b0;
   logic [N-1:0] pad_out, pad_oe, core_in;
   logic core_rst_in;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bscan_pad_chain #(.NUM_PADS(N)) u0 (.*);

   // vector: ext int core_out core_oe pad_in rst | pad_out pad_oe core_in core_rst
   localparam logic [27:0] VECS [0:5] = '{
      {1'b0,1'b0,4'b0011,4'b1111,4'b1100,1'b1, 4'b0011,4'b1111,4'b1100,1'b1},
      {1'b1,1'b0,4'b0011,4'b1111,4'b1100,1'b0, 4'b1001,4'b0111,4'b1100,1'b0},
      {1'b0,1'b1,4'b0011,4'b0000,4'b1100,1'b1, 4'b0011,4'b0000,4'b0101,1'b1},
      {1'b1,1'b1,4'b1110,4'b0001,4'b0010,1'b0, 4'b1001,4'b0111,4'b0101,1'b0},
      {1'b0,1'b0,4'b1110,4'b0001,4'b0010,1'b0, 4'b1110,4'b0001,4'b0010,1'b0},
      {1'b1,1'b0,4'b0000,4'b0000,4'b1111,1'b1, 4'b1001,4'b0111,4'b1111,1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // chain image: bit 0 reset cell, pad p at 3p+1 (in), 3p+2 (out), 3p+3 (oe)
   function automatic logic [L-1:0] image(input logic [N-1:0] i, input logic [N-1:0] o,
                                          input logic [N-1:0] e, input logic r);
      logic [L-1:0] v;
      v[0] = r;
      for (int p = 0; p < N; p++) begin
         v[3*p+1] = i[p];
         v[3*p+2] = o[p];
         v[3*p+3] = e[p];
      end
      return v;
   endfunction

   task automatic do_capture();
      capture_dr = 1'b1;
      tick();
      capture_dr = 1'b0;
   endtask

   task automatic do_update();
      update_dr = 1'b1;
      tick();
      update_dr = 1'b0;
   endtask

   // read L bits from tdo while loading new_img through tdi
   task automatic scan(input logic [L-1:0] new_img, output logic [L-1:0] got);
      for (int k = 0; k < L; k++) begin
         got[k] = tdo;
         tdi = new_img[k];
         shift_dr = 1'b1;
         tick();
         shift_dr = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [L-1:0] got;
      logic [L-1:0] pre;
      logic [L-1:0] prev;
      logic [N-1:0] hold_po;
      logic hold_tdo;

      core_out = 4'b0110; core_oe = 4'b1100; pad_in = 4'b1010; rst_pin = 1'b1;
      repeat (3) tick();
      // R1: reset state
      check("R1 tdo", tdo, 0);
      check("R1 pad_out", pad_out, 4'b0110);
      check("R1 core_in", core_in, 4'b1010);
      rst_n = 1'b1;
      tick();
      extest_en = 1'b1; intest_en = 1'b1;
      #1;
      check("R1 update flops zero (pad_out)", pad_out, 0);
      check("R1 update flops zero (core_in)", core_in, 0);
      extest_en = 1'b0; intest_en = 1'b0;

      // R2/R3: capture and shift out, loading a preload image
      chain_sel = 1'b1;
      pre = image(4'b0101, 4'b1001, 4'b0111, 1'b1);
      do_capture();
      check("R2 tdo after capture", tdo, 1);
      scan(pre, got);
      check("R2 R3 captured stream", got, image(4'b1010, 4'b0110, 4'b1100, 1'b1));

      // R5: no update yet -> overrides still show zeros
      extest_en = 1'b1; intest_en = 1'b1;
      #1;
      check("R5 hold during shift pad_out", pad_out, 0);
      check("R5 hold during shift pad_oe", pad_oe, 0);
      extest_en = 1'b0; intest_en = 1'b0;
      do_update();

      // vector table: modes R6 R7 R8 R9
      for (int v = 0; v < 6; v++) begin
         extest_en = VECS[v][27]; intest_en = VECS[v][26];
         core_out = VECS[v][25:22]; core_oe = VECS[v][21:18];
         pad_in = VECS[v][17:14]; rst_pin = VECS[v][13];
         tick();
         check($sformatf("R6 R9 pad_out vec%0d", v), pad_out, VECS[v][12:9]);
         check($sformatf("R6 R9 pad_oe vec%0d", v), pad_oe, VECS[v][8:5]);
         check($sformatf("R7 R9 core_in vec%0d", v), core_in, VECS[v][4:1]);
         check($sformatf("R8 core_rst_in vec%0d", v), core_rst_in, VECS[v][0]);
      end

      // R10: deselected strobes are ignored
      extest_en = 1'b1; intest_en = 1'b1;
      tick();
      hold_tdo = tdo;
      hold_po = pad_out;
      chain_sel = 1'b0;
      core_out = 4'b1111; pad_in = 4'b0000; rst_pin = ~hold_tdo;
      do_capture();
      shift_dr = 1'b1; tdi = ~hold_tdo; tick(); tick(); shift_dr = 1'b0;
      do_update();
      check("R10 tdo unchanged", tdo, hold_tdo);
      check("R10 pad_out unchanged", pad_out, hold_po);
      check("R10 core_in unchanged", core_in, 4'b0101);

      // R2: capture in override mode, capture wins over shift
      chain_sel = 1'b1;
      core_out = 4'b1100; core_oe = 4'b0011; pad_in = 4'b1001; rst_pin = 1'b0;
      capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
      tick();
      capture_dr = 1'b0; shift_dr = 1'b0;
      check("R2 capture beats shift", tdo, 0);
      scan({L{1'b1}}, got);
      check("R2 capture under override", got, image(4'b1001, 4'b1100, 4'b0011, 1'b0));
      check("R5 hold while shifting in override", pad_out, 4'b1001);
      do_update();
      check("R5 update in override pad_out", pad_out, 4'b1111);
      check("R5 update in override pad_oe", pad_oe, 4'b1111);
      check("R7 update in override core_in", core_in, 4'b1111);

      // R4: chain length - ones fed earlier leave after exactly L shifts
      prev = '0;
      scan('0, got);
      check("R4 first L bits are the ones fed", got, {L{1'b1}});
      check("R4 zero arrives after L shifts", tdo, 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule